// File: doc/BRIEF.md
# PLL Channel Output Divider

This block sits behind one output of a PLL and turns its fast clock into a slower, gateable channel clock. Software programs an integer divide field and a stop bit through a small control register. A separate hold input, driven from a register the channel shares with its parent PLL, also parks the output. A per-instance parameter adds a fixed post-divider of 1 or 2, so the total divide is the programmed value times that fixed factor.

The output comes straight from a flop clocked by the PLL clock, so it cannot glitch. A new divide value is picked up only when the current period ends. When the channel is released from stop or hold, it restarts at the start of a period with a rising edge. When the PLL clock stops, the output freezes with it.

Top module: `pll_chan_div`

## Requirements
- R1: During reset the output is low and the control register loads the parameter `RESET_CTRL` (default: stop bit clear, divide field 4). A write (`cfg_we` high at a rising `pll_clk` edge) replaces the whole register.
- R2: Control word layout: bits [DIV_W-1:0] hold the divide field and bit DIV_W is the stop bit. While the stop bit is set, the output is low from the first clock edge after the write lands.
- R3: While `hold` is high at a clock edge, the output is low after that edge. The stop bit has no part in this.
- R4: With a total divide N, each output period lasts N input cycles: high for floor(N/2) cycles, then low for the remaining cycles. Even N therefore gives 50% duty, and for odd N the high phase is one cycle shorter than the low phase.
- R5: N = D × FIXED_DIV, where D is the divide field. A field value of 0 means the field maximum (255 for 8 bits).
- R6: If D × FIXED_DIV works out to 1, N is raised to 2, the smallest period a flop output can produce.
- R7: A divide value written during a period does not change that period. It takes effect from the next period boundary.
- R8: At the first clock edge at which neither stop nor hold applies, the output goes high and begins a full period.
- R9: While the PLL clock is not toggling, the output keeps its value and shows no edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pll_clk | input | 1 | Fast clock from the parent PLL |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the control register |
| cfg_wdata | input | DIV_W+1 | New control word: stop bit on top, divide field below |
| hold | input | 1 | Channel hold from the shared PLL register, active high |
| clk_out | output | 1 | Divided channel clock |

## Verification
The hardest case to reach is a divide change that lands in the middle of a period. The bench has to catch the exact cycle of a rising output edge and issue the write on that cycle. It then measures the period in flight, which must keep the old high and low lengths, and the period after it, which must use the new lengths. Restart after stop or hold is checked the same way, counting from the first sample after release. Random divide values run on instances with both fixed factors, including the zero and divide-of-one corners.

// File: rtl/pchdiv_pkg.sv
package pchdiv_pkg;

  // Raw total divide: field value (zero maps to the field maximum) times the fixed factor
  function automatic int unsigned raw_total(int unsigned field, int unsigned field_max,
                                            int unsigned fixed_div);
    int unsigned d;
    d = (field == 0) ? field_max : field;
    return d * fixed_div;
  endfunction

  // Cycles the output stays high within a period of the given length
  function automatic int unsigned high_cycles(int unsigned total);
    return total / 2;
  endfunction

endpackage

// File: rtl/pchdiv_cfg_reg.sv
module pchdiv_cfg_reg #(
  parameter int unsigned CTRL_W = 9,
  parameter logic [CTRL_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctrl_q <= RESET_VAL;
    else if (we) ctrl_q <= wdata;
  end
endmodule

// File: rtl/pchdiv_counter.sv
module pchdiv_counter #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] total_cur,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] per_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic [CNT_W-1:0] per_nxt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  assign wrap = (cnt_q == per_q - ONE);

  always_comb begin
    if (!run) begin
      // parked on the last count so the first running edge opens a new period
      cnt_nxt = total_cur - ONE;
      per_nxt = total_cur;
    end else if (wrap) begin
      cnt_nxt = '0;
      per_nxt = total_cur;
    end else begin
      cnt_nxt = cnt_q + ONE;
      per_nxt = per_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ONE;
      per_q <= TWO;
    end else begin
      cnt_q <= cnt_nxt;
      per_q <= per_nxt;
    end
  end
endmodule

// File: rtl/pchdiv_phase.sv
module pchdiv_phase #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] per_nxt,
  output logic             out_q
);
  logic [CNT_W-1:0] hi_len;
  assign hi_len = CNT_W'(pchdiv_pkg::high_cycles(32'(per_nxt)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= run && (cnt_nxt < hi_len);
  end
endmodule

// File: rtl/pll_chan_div.sv
module pll_chan_div #(
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned FIXED_DIV = 1,
  parameter logic [DIV_W:0] RESET_CTRL = {1'b0, DIV_W'(4)}
) (
  input  logic           pll_clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [DIV_W:0] cfg_wdata,
  input  logic           hold,
  output logic           clk_out
);
  localparam int unsigned CTRL_W    = DIV_W + 1;
  localparam int unsigned DIV_MAX   = (1 << DIV_W) - 1;
  localparam int unsigned MAX_TOTAL = DIV_MAX * FIXED_DIV;
  localparam int unsigned CNT_W     = $clog2(MAX_TOTAL + 1);

  logic [CTRL_W-1:0] ctrl_q;
  logic [DIV_W-1:0]  div_field;
  logic              stop_bit;
  logic              run;
  logic [CNT_W-1:0]  raw_cur;
  logic [CNT_W-1:0]  total_cur;
  logic [CNT_W-1:0]  cnt_q, per_q, cnt_nxt, per_nxt;
  logic              wrap_ev;

  pchdiv_cfg_reg #(.CTRL_W(CTRL_W), .RESET_VAL(RESET_CTRL)) u_cfg (
    .clk(pll_clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .ctrl_q(ctrl_q)
  );

  assign div_field = ctrl_q[DIV_W-1:0];
  assign stop_bit  = ctrl_q[DIV_W];
  assign run       = !stop_bit && !hold;
  assign raw_cur   = CNT_W'(pchdiv_pkg::raw_total(32'(div_field), DIV_MAX, FIXED_DIV));

  generate
    if (FIXED_DIV == 1) begin : gen_clamp
      assign total_cur = (raw_cur < CNT_W'(2)) ? CNT_W'(2) : raw_cur;
    end else begin : gen_noclamp
      assign total_cur = raw_cur;
    end
  endgenerate

  pchdiv_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(pll_clk), .rst_n(rst_n), .run(run), .total_cur(total_cur),
    .cnt_q(cnt_q), .per_q(per_q), .cnt_nxt(cnt_nxt), .per_nxt(per_nxt), .wrap(wrap_ev)
  );

  pchdiv_phase #(.CNT_W(CNT_W)) u_phase (
    .clk(pll_clk), .rst_n(rst_n), .run(run),
    .cnt_nxt(cnt_nxt), .per_nxt(per_nxt), .out_q(clk_out)
  );
endmodule

// File: rtl/pll_chan_div_chk.sv
module pll_chan_div_chk #(
  parameter int unsigned CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hold,
  input logic             stop_bit,
  input logic             run,
  input logic             wrap,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] per_q,
  input logic             clk_out
);
  logic run_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_prev <= 1'b0;
    else        run_prev <= run;
  end

  // R2
  stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n) stop_bit |=> !clk_out);
  // R3
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n) hold |=> !clk_out);
  // R8
  restart_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !run_prev) |=> clk_out);
  // R7
  per_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(per_q));
  // R6
  per_min_chk: assert property (@(posedge clk) disable iff (!rst_n) per_q >= CNT_W'(2));
  // R4
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt_q < per_q);
endmodule

bind pll_chan_div pll_chan_div_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(pll_clk), .rst_n(rst_n), .hold(hold), .stop_bit(stop_bit), .run(run),
  .wrap(wrap_ev), .cnt_q(cnt_q), .per_q(per_q), .clk_out(clk_out)
);

// File: tb/tb_pll_chan_div.sv
`timescale 1ns/1ps
module tb_pll_chan_div;
  logic clk = 1'b0;
  logic clk_en = 1'b1;
  logic pll_clk;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [8:0] cfg_wdata = '0;
  logic hold = 1'b0;
  logic out2, out1;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign pll_clk = clk & clk_en;

  pll_chan_div #(.DIV_W(8), .FIXED_DIV(2)) dut (
    .pll_clk(pll_clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .hold(hold), .clk_out(out2));
  pll_chan_div #(.DIV_W(8), .FIXED_DIV(1)) dut_f1 (
    .pll_clk(pll_clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .hold(hold), .clk_out(out1));

  function automatic int exp_n(int d, int fixed);
    int t;
    t = ((d == 0) ? 255 : d) * fixed;
    return (t < 2) ? 2 : t;
  endfunction

  function automatic logic o(bit s);
    return s ? out1 : out2;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(logic stop, logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = {stop, d};
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wait_rise(bit s);
    logic prev;
    prev = o(s);
    forever begin
      @(negedge clk);
      if (!prev && o(s)) break;
      prev = o(s);
    end
  endtask

  // Starts at the sample that shows a fresh rise; ends at the next rise.
  task automatic measure_wr(bit s, bit do_wr, logic [7:0] d, output int hi, output int lo);
    if (do_wr) begin cfg_we = 1'b1; cfg_wdata = {1'b0, d}; end
    hi = 1;
    forever begin
      @(negedge clk); cfg_we = 1'b0;
      if (o(s)) hi++; else break;
    end
    lo = 1;
    forever begin
      @(negedge clk);
      if (!o(s)) lo++; else break;
    end
  endtask

  task automatic check_period(bit s, int n, string req);
    int hi, lo;
    measure_wr(s, 1'b0, 8'd0, hi, lo);
    chk(hi == n / 2, req, hi, n / 2);
    chk(lo == n - n / 2, req, lo, n - n / 2);
  endtask

  task automatic settle_and_check(bit s, int n, string req);
    wait_rise(s); wait_rise(s);
    check_period(s, n, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int hi, lo;
    logic held2, held1;
    void'($urandom(32'd7331));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(out2 == 1'b0, "R1 reset low", out2, 0);
    chk(out1 == 1'b0, "R1 reset low", out1, 0);
    rst_n = 1'b1;
    wait_rise(0);
    check_period(0, exp_n(4, 2), "R1 default divide");

    // R4: even and odd totals
    write_cfg(1'b0, 8'd3);
    settle_and_check(0, exp_n(3, 2), "R4 even");
    settle_and_check(1, exp_n(3, 1), "R4 odd");
    write_cfg(1'b0, 8'd7);
    settle_and_check(1, exp_n(7, 1), "R4 odd7");

    // R5: zero field means maximum
    write_cfg(1'b0, 8'd0);
    settle_and_check(0, exp_n(0, 2), "R5 zero");
    settle_and_check(1, exp_n(0, 1), "R5 zero");

    // R6: total of one raised to two
    write_cfg(1'b0, 8'd1);
    settle_and_check(1, 2, "R6 min");
    settle_and_check(0, exp_n(1, 2), "R6 fixed2");

    // R7: change during a period
    write_cfg(1'b0, 8'd3);
    wait_rise(0); wait_rise(0);
    measure_wr(0, 1'b1, 8'd5, hi, lo);
    chk(hi == 3 && lo == 3, "R7 in-flight hi", hi, 3);
    chk(lo == 3, "R7 in-flight lo", lo, 3);
    check_period(0, exp_n(5, 2), "R7 next period");

    // R3: hold
    @(negedge clk); hold = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(out2 == 1'b0 && out1 == 1'b0, "R3 hold low", out2 | out1, 0);
    end
    hold = 1'b0;
    @(negedge clk);
    chk(out2 == 1'b1, "R8 rise after hold", out2, 1);
    check_period(0, exp_n(5, 2), "R8 full period after hold");

    // R2: stop bit
    write_cfg(1'b1, 8'd5);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(out2 == 1'b0 && out1 == 1'b0, "R2 stop low", out2 | out1, 0);
    end
    write_cfg(1'b0, 8'd5);
    @(negedge clk);
    chk(out2 == 1'b1, "R8 rise after stop", out2, 1);
    check_period(0, exp_n(5, 2), "R8 full period after stop");

    // R9: input clock halted
    @(negedge clk); clk_en = 1'b0;
    held2 = out2; held1 = out1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk(out2 == held2 && out1 == held1, "R9 frozen", out2, held2);
    end
    clk_en = 1'b1;

    // R4 R5: random divides
    for (int it = 0; it < 16; it++) begin
      logic [7:0] d;
      d = (it == 0) ? 8'd255 : 8'($urandom_range(0, 40));
      write_cfg(1'b0, d);
      settle_and_check(0, exp_n(d, 2), "R4 random fixed2");
      settle_and_check(1, exp_n(d, 1), "R4 random fixed1");
    end

    finish_run();
  end
endmodule